// File: doc/BRIEF.md
# Slowdown-Proportional Priority Slicer

This block shares memory-controller top priority among several applications over a fixed quantum of cycles. Each application gets a run of consecutive cycles whose length is proportional to its estimated slowdown. An application that is held back more gets a longer time at the head of the queue. While it is at the head, its memory traffic behaves almost as if it ran alone. The slowdown figures may come from an upstream cache-partitioning controller, so that cache and bandwidth allocation follow the same estimates.

A one-cycle quantum-start pulse captures a vector of unsigned slowdowns, one per application. In that same cycle the block divides the quantum into integer slices and begins the new quantum on the next cycle. Slices run in ascending application index, and a slice of zero length is skipped. The block drives a one-hot select and a matching binary index that name the application holding top priority in each cycle. If no new pulse arrives, the same slice pattern repeats every quantum. A pulse that arrives part way through a quantum ends that quantum at once.

Top module: `slowdown_prio_slicer`

## Requirements
- R1: For every application except the highest-indexed one, the slice length is floor(s_i * QUANTUM / S). Here s_i is the application's slowdown field, taken from bits [i*SLOW_W +: SLOW_W] of `slowdowns`, and S is the sum of all fields.
- R2: The highest-indexed application receives QUANTUM minus the sum of all other slices, so the slices always add up to exactly QUANTUM.
- R3: When every slowdown field is zero, each application except the highest-indexed one gets floor(QUANTUM / NUM_APPS) cycles, and the highest-indexed one gets the rest.
- R4: Within a quantum, slices are granted in ascending application index, each as one contiguous run of cycles. An application with a zero-length slice is never selected.
- R5: In every cycle exactly one bit of `prioSel` is set, and `prioId` is the index of that bit.
- R6: The selected application changes only at a slice boundary, or on the cycle after a quantum-start pulse.
- R7: A quantum-start pulse sampled at a clock edge causes the first cycle after that edge to be offset 0 of a new quantum built from the slowdowns sampled at that edge. Any quantum in progress is abandoned.
- R8: If no quantum-start pulse arrives, the slice sequence repeats with period QUANTUM, using the most recently loaded slices.
- R9: After reset, the block behaves as if an all-zero slowdown vector had just been loaded: application 0 is selected, and the R3 split applies from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quantumStart | input | 1 | One-cycle pulse: load slowdowns and begin a new quantum |
| slowdowns | input | NUM_APPS*SLOW_W | Packed per-application slowdown fields, application i at [i*SLOW_W +: SLOW_W] |
| prioSel | output | NUM_APPS | One-hot top-priority select |
| prioId | output | IDX_W | Binary index of the selected application |

## Verification
The bench builds the block with four applications, 4-bit slowdown fields and a 64-cycle quantum. These small values keep each quantum short enough to follow cycle by cycle. They also let the bench sweep a grid of 625 slowdown vectors, in which every field is one of 0, 1, 3, 7 and 15. The grid includes the all-zero vector and vectors with single or multiple zero fields, so empty slices and the equal split are covered. It also includes vectors whose floor division leaves a remainder for the last application. Each vector runs past the end of its quantum before the next pulse arrives, so wrap-around and a restart in the middle of a slice are checked for every vector.

// File: rtl/prio_slicer_pkg.sv
package prio_slicer_pkg;

  // Strobes from the sequencing control to the slice datapath.
  typedef struct packed {
    logic loadNew;    // capture freshly computed slices, count from new slice
    logic reload;     // start the next slice from the stored slices
    logic countDown;  // stay inside the current slice
  } sliceStrobe_t;

endpackage

// File: rtl/prio_slicer_datapath.sv
module prio_slicer_datapath
  import prio_slicer_pkg::*;
#(
  parameter int NUM_APPS = 4,
  parameter int SLOW_W   = 8,
  parameter int QUANTUM  = 4096,
  localparam int IDX_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
  localparam int QW      = $clog2(QUANTUM + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_APPS*SLOW_W-1:0] slowdowns,
  input  sliceStrobe_t               strobe,
  input  logic [IDX_W-1:0]           nextIdx,
  output logic [NUM_APPS-1:0]        newNz,
  output logic [NUM_APPS-1:0]        curNz,
  output logic                       lastCycle,
  output logic [QW-1:0]              sliceLeft,
  output logic [NUM_APPS*QW-1:0]     shareFlat
);

  localparam int SUMW    = SLOW_W + IDX_W + 1;
  localparam int PRODW   = SLOW_W + QW;
  localparam int ACCW    = QW + IDX_W + 1;
  localparam int EQ      = QUANTUM / NUM_APPS;
  localparam int EQLAST  = QUANTUM - EQ * (NUM_APPS - 1);
  localparam int CNT_RST = (NUM_APPS == 1) ? EQLAST : EQ;

  logic [SLOW_W-1:0] slow     [NUM_APPS];
  logic [QW-1:0]     newShare [NUM_APPS];
  logic [QW-1:0]     shareReg [NUM_APPS];
  logic [SUMW-1:0]   sumAll;
  logic              allZero;
  logic [PRODW-1:0]  divisor;
  logic [ACCW-1:0]   accOthers;
  logic [QW-1:0]     cnt;

  // Unpack the slowdown fields.
  for (genvar i = 0; i < NUM_APPS; i++) begin : gUnpack
    assign slow[i] = slowdowns[i*SLOW_W +: SLOW_W];
  end

  always_comb begin
    sumAll = '0;
    for (int i = 0; i < NUM_APPS; i++) sumAll = sumAll + SUMW'(slow[i]);
  end

  assign allZero = (sumAll == '0);
  assign divisor = allZero ? PRODW'(1) : PRODW'(sumAll);

  // Proportional share for every application but the last one.
  for (genvar i = 0; i < NUM_APPS - 1; i++) begin : gDivide
    logic [PRODW-1:0] prod;
    logic [QW-1:0]    quotTrim;
    assign prod     = PRODW'(slow[i]) * PRODW'(QUANTUM);
    assign quotTrim = QW'(prod / divisor);
    assign newShare[i] = allZero ? QW'(EQ) : quotTrim;
  end

  always_comb begin
    accOthers = '0;
    for (int i = 0; i < NUM_APPS - 1; i++) accOthers = accOthers + ACCW'(newShare[i]);
  end

  // The last application absorbs the division remainder.
  assign newShare[NUM_APPS-1] = QW'(ACCW'(QUANTUM) - accOthers);

  // Slice storage, reset to the equal split.
  for (genvar i = 0; i < NUM_APPS; i++) begin : gStore
    localparam int RSTV = (i == NUM_APPS - 1) ? EQLAST : EQ;
    always_ff @(posedge clk) begin
      if (!rst_n)              shareReg[i] <= QW'(RSTV);
      else if (strobe.loadNew) shareReg[i] <= newShare[i];
    end
    assign newNz[i] = (newShare[i] != '0);
    assign curNz[i] = (shareReg[i] != '0);
    assign shareFlat[i*QW +: QW] = shareReg[i];
  end

  // Cycles left in the current slice, including this one.
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= QW'(CNT_RST);
    else if (strobe.loadNew)   cnt <= newShare[nextIdx];
    else if (strobe.reload)    cnt <= shareReg[nextIdx];
    else if (strobe.countDown) cnt <= cnt - QW'(1);
  end

  assign lastCycle = (cnt == QW'(1));
  assign sliceLeft = cnt;

endmodule

// File: rtl/prio_slicer_control.sv
module prio_slicer_control
  import prio_slicer_pkg::*;
#(
  parameter int NUM_APPS = 4,
  localparam int IDX_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                quantumStart,
  input  logic [NUM_APPS-1:0] newNz,
  input  logic [NUM_APPS-1:0] curNz,
  input  logic                lastCycle,
  output sliceStrobe_t        strobe,
  output logic [IDX_W-1:0]    nextIdx,
  output logic [IDX_W-1:0]    curApp
);

  // Lowest set position of a mask.
  function automatic logic [IDX_W-1:0] firstOf(input logic [NUM_APPS-1:0] mask);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_APPS - 1; i >= 0; i--) if (mask[i]) r = IDX_W'(i);
    return r;
  endfunction

  // Lowest set position above the current application, wrapping to the first.
  function automatic logic [IDX_W-1:0] nextAfter(input logic [NUM_APPS-1:0] mask,
                                                 input logic [IDX_W-1:0] cur);
    logic [IDX_W-1:0] r;
    logic             found;
    r     = firstOf(mask);
    found = 1'b0;
    for (int i = 0; i < NUM_APPS; i++) begin
      if (!found && mask[i] && (IDX_W'(i) > cur)) begin
        r     = IDX_W'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    strobe  = '0;
    nextIdx = curApp;
    if (quantumStart) begin
      strobe.loadNew = 1'b1;
      nextIdx        = firstOf(newNz);
    end else if (lastCycle) begin
      strobe.reload = 1'b1;
      nextIdx       = nextAfter(curNz, curApp);
    end else begin
      strobe.countDown = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) curApp <= '0;
    else        curApp <= nextIdx;
  end

endmodule

// File: rtl/slowdown_prio_slicer.sv
module slowdown_prio_slicer
  import prio_slicer_pkg::*;
#(
  parameter int NUM_APPS = 4,
  parameter int SLOW_W   = 8,
  parameter int QUANTUM  = 4096,
  localparam int IDX_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       quantumStart,
  input  logic [NUM_APPS*SLOW_W-1:0] slowdowns,
  output logic [NUM_APPS-1:0]        prioSel,
  output logic [IDX_W-1:0]           prioId
);

  localparam int QW = $clog2(QUANTUM + 1);

  sliceStrobe_t            strobe;
  logic [IDX_W-1:0]        nextIdx;
  logic [IDX_W-1:0]        curApp;
  logic [NUM_APPS-1:0]     newNz;
  logic [NUM_APPS-1:0]     curNz;
  logic                    lastCycle;
  logic [QW-1:0]           sliceLeft;
  logic [NUM_APPS*QW-1:0]  shareFlat;

  prio_slicer_control #(.NUM_APPS(NUM_APPS)) ctrl (
    .clk(clk), .rst_n(rst_n), .quantumStart(quantumStart),
    .newNz(newNz), .curNz(curNz), .lastCycle(lastCycle),
    .strobe(strobe), .nextIdx(nextIdx), .curApp(curApp)
  );

  prio_slicer_datapath #(.NUM_APPS(NUM_APPS), .SLOW_W(SLOW_W), .QUANTUM(QUANTUM)) dp (
    .clk(clk), .rst_n(rst_n), .slowdowns(slowdowns),
    .strobe(strobe), .nextIdx(nextIdx),
    .newNz(newNz), .curNz(curNz), .lastCycle(lastCycle),
    .sliceLeft(sliceLeft), .shareFlat(shareFlat)
  );

  always_comb begin
    prioSel         = '0;
    prioSel[curApp] = 1'b1;
  end

  assign prioId = curApp;

endmodule

// File: rtl/slowdown_prio_slicer_chk.sv
module slowdown_prio_slicer_chk #(
  parameter int NUM_APPS = 4,
  parameter int QUANTUM  = 4096,
  localparam int IDX_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
  localparam int QW      = $clog2(QUANTUM + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   quantumStart,
  input logic [NUM_APPS-1:0]    prioSel,
  input logic [IDX_W-1:0]       prioId,
  input logic                   lastCycle,
  input logic [QW-1:0]          sliceLeft,
  input logic [NUM_APPS*QW-1:0] shareFlat
);

  localparam int TW = QW + IDX_W + 1;

  function automatic logic [TW-1:0] shareTotal(input logic [NUM_APPS*QW-1:0] f);
    logic [TW-1:0] t;
    t = '0;
    for (int i = 0; i < NUM_APPS; i++) t = t + TW'(f[i*QW +: QW]);
    return t;
  endfunction

  // Quantum phase tracker for the repeat check.
  logic [QW-1:0]       phase;
  logic                justStarted;
  logic [NUM_APPS-1:0] refSel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= '0;
      justStarted <= 1'b1;
      refSel      <= '0;
    end else begin
      if (quantumStart)                      phase <= '0;
      else if (phase == QW'(QUANTUM - 1))    phase <= '0;
      else                                   phase <= phase + QW'(1);
      justStarted <= quantumStart;
      if (justStarted && phase == '0) refSel <= prioSel;
    end
  end

  assert_one_hot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prioSel) == 1 && prioSel[prioId]);

  assert_change_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prioSel) |-> ($past(quantumStart) || $past(lastCycle)));

  assert_slice_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sliceLeft != '0);

  assert_share_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shareTotal(shareFlat) == TW'(QUANTUM));

  assert_wrap_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0 && !justStarted) |-> prioSel == refSel);

endmodule

bind slowdown_prio_slicer slowdown_prio_slicer_chk #(.NUM_APPS(NUM_APPS), .QUANTUM(QUANTUM)) chkInst (
  .clk(clk), .rst_n(rst_n), .quantumStart(quantumStart),
  .prioSel(prioSel), .prioId(prioId), .lastCycle(lastCycle),
  .sliceLeft(sliceLeft), .shareFlat(shareFlat)
);

// File: tb/slowdown_prio_slicer_test.sv
module slowdown_prio_slicer_test;

  localparam int N  = 4;
  localparam int SW = 4;
  localparam int Q  = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          quantumStart = 1'b0;
  logic [N*SW-1:0] slowdowns = '0;
  logic [N-1:0]  prioSel;
  logic [1:0]    prioId;

  int total = 0;
  int bad   = 0;
  int expShare [N];
  bit expZero;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  slowdown_prio_slicer #(.NUM_APPS(N), .SLOW_W(SW), .QUANTUM(Q)) uut (
    .clk(clk), .rst_n(rst_n), .quantumStart(quantumStart),
    .slowdowns(slowdowns), .prioSel(prioSel), .prioId(prioId)
  );

  task automatic setExpected(input logic [N*SW-1:0] v);
    int sum = 0;
    int rest = 0;
    for (int i = 0; i < N; i++) sum += int'(v[i*SW +: SW]);
    expZero = (sum == 0);
    for (int i = 0; i < N - 1; i++) begin
      expShare[i] = expZero ? Q / N : (int'(v[i*SW +: SW]) * Q) / sum;
      rest += expShare[i];
    end
    expShare[N-1] = Q - rest;
  endtask

  function automatic int expAppAt(input int k);
    int km = k % Q;
    int cum = 0;
    for (int i = 0; i < N; i++) begin
      cum += expShare[i];
      if (km < cum) return i;
    end
    return N - 1;
  endfunction

  task automatic checkCycle(input int k, input string forcedTag);
    int e = expAppAt(k);
    string tag;
    if (forcedTag != "")      tag = forcedTag;
    else if (expZero)         tag = "R3";
    else if (k >= Q)          tag = "R8";
    else if (e == N - 1)      tag = "R2";
    else if (k > 0 && expAppAt(k - 1) == e) tag = "R6";
    else                      tag = "R1/R4";
    total++;
    if ($countones(prioSel) != 1 || !prioSel[prioId]) begin
      bad++;
      $display("FAIL R5 offset %0d: prioSel=%b prioId=%0d expected one-hot matching id", k, prioSel, prioId);
    end
    total++;
    if (int'(prioId) != e || prioSel != N'(1 << e)) begin
      bad++;
      $display("FAIL %s offset %0d: prioId=%0d prioSel=%b expected id=%0d sel=%b",
               tag, k, prioId, prioSel, e, N'(1 << e));
    end
  endtask

  // Pulse quantumStart for one edge; returns at the negedge showing offset 0.
  task automatic startQuantum(input logic [N*SW-1:0] v);
    @(negedge clk);
    slowdowns    = v;
    quantumStart = 1'b1;
    @(negedge clk);
    quantumStart = 1'b0;
    setExpected(v);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    int lv [5] = '{0, 1, 3, 7, 15};
    repeat (3) @(negedge clk);
    // R9: reset state is the equal split starting at application 0.
    rst_n = 1'b1;
    setExpected('0);
    for (int k = 0; k < Q + 5; k++) begin
      checkCycle(k, (k == 0) ? "R9" : "");
      @(negedge clk);
    end

    // R7: restart in the middle of a slice with a skewed vector.
    startQuantum({4'd1, 4'd0, 4'd0, 4'd15});
    for (int k = 0; k < 5; k++) begin
      checkCycle(k, "");
      @(negedge clk);
    end
    startQuantum({4'd0, 4'd7, 4'd3, 4'd0});
    checkCycle(0, "R7");

    // Grid sweep: each field drawn from lv[]; runs past one quantum.
    for (int code = 0; code < 625; code++) begin
      logic [N*SW-1:0] v;
      int c = code;
      for (int i = 0; i < N; i++) begin
        v[i*SW +: SW] = SW'(lv[c % 5]);
        c = c / 5;
      end
      startQuantum(v);
      for (int k = 0; k < Q + 3; k++) begin
        checkCycle(k, (k == 0) ? "R7" : "");
        @(negedge clk);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule